// File: doc/BRIEF.md
# Packet Destination Address Filter

This block decides, for every incoming packet, whether the receive path should keep it. The decision is based only on the packet's destination host number. There are two ways to decide. In single-host mode, one programmed host number is compared against the destination. In multicast mode, a software-loaded accept bitmap holds one bit for each possible destination, and the destination's bit decides. Destination 0 is the broadcast address.

Software programs the filter through a small write port with four targets, selected by `wr_sel`. These are the host word, one bitmap word, a control word, and the dropped-packet counter. Writing all ones to the host word switches the filter to multicast mode. Writing any other value switches it back to single-host mode. A control bit turns off broadcast acceptance.

Each destination arrives with a one-cycle strobe. The verdict comes back on a registered output one cycle later. A packet that passes the filter while the receiver has no buffer ready is refused and counted in a saturating counter. Software clears that counter by writing to it. A packet and a register write in the same cycle are judged against the register values from before the write.

Top module: `pkt_dest_filter`

## Requirements
- R1: After reset, `acc_valid` and `acc_ok` are low and `missed_count` is 0. The host word resets to 0, broadcast acceptance is on, every bitmap bit is clear, and `multicast_mode` is low.
- R2: In single-host mode, a nonzero destination is accepted only when it equals the host word. Destination 0 is accepted whenever broadcast acceptance is on, including when the host word is 0.
- R3: Writing the control word (`wr_sel`=2) with bit 0 set turns broadcast acceptance off. Destination 0 is then refused in single-host mode. Writing it with bit 0 clear turns broadcast acceptance back on.
- R4: Writing all ones to the host word (`wr_sel`=0) raises `multicast_mode` from the next cycle. From then on, the bitmap bit indexed by the destination alone decides acceptance, for destination 0 as well.
- R5: A bitmap write (`wr_sel`=1) replaces a whole word. Bit n of word `wr_idx`=k covers destination k*WORD_W+n. Any number of destinations, from none to all, can be selected at once.
- R6: Writing any host value other than all ones returns the filter to single-host mode, with `multicast_mode` low. A host value with its top bit set, other than all ones, matches no destination, so only broadcast can pass.
- R7: `acc_valid` is high exactly in the cycle after `dst_valid` was high. `acc_ok` is never high without `acc_valid`.
- R8: A destination that passes the filter while `buf_ready` is low gives `acc_ok` low and adds 1 to `missed_count`. A refused destination never changes the counter.
- R9: `missed_count` stops at its all-ones value and stays there.
- R10: Any write to the counter (`wr_sel`=3) clears it to 0, whatever `wr_data` holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Write target: 0 host, 1 bitmap word, 2 control, 3 counter clear |
| wr_idx | input | WIDX_W | Bitmap word index |
| wr_data | input | WORD_W | Write data |
| dst_valid | input | 1 | Destination byte strobe |
| dst_addr | input | ADDR_W | Destination host number |
| buf_ready | input | 1 | A receive buffer is available |
| acc_valid | output | 1 | Verdict valid (one cycle after strobe) |
| acc_ok | output | 1 | Packet accepted |
| multicast_mode | output | 1 | Bitmap lookup mode active |
| missed_count | output | CNT_W | Saturating count of packets dropped for lack of a buffer |

## Verification
The bench builds the filter with a 6-bit destination and 8-bit words, which gives 64 destinations over 8 bitmap words. It also uses a 4-bit counter. With these values, every destination can be swept under each host and bitmap setting, and each verdict is compared with one the bench computes arithmetically. The 4-bit counter reaches saturation after fifteen refused packets, so both the stop at the maximum and the clear are checked in a short run.

// File: rtl/pdf_pkg.sv
package pdf_pkg;

    typedef enum logic [1:0] {
        SEL_HOST = 2'd0,
        SEL_VEC  = 2'd1,
        SEL_CTRL = 2'd2,
        SEL_MISS = 2'd3
    } pdf_sel_e;

endpackage

// File: rtl/pdf_cfg_regs.sv
module pdf_cfg_regs #(
    parameter int ADDR_W = 8,
    parameter int WORD_W = 16,
    localparam int NUM_DEST  = 1 << ADDR_W,
    localparam int NUM_WORDS = NUM_DEST / WORD_W,
    localparam int WIDX_W    = (NUM_WORDS > 1) ? $clog2(NUM_WORDS) : 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  pdf_pkg::pdf_sel_e    wr_sel,
    input  logic [WIDX_W-1:0]    wr_idx,
    input  logic [WORD_W-1:0]    wr_data,
    output logic [WORD_W-1:0]    host_q,
    output logic                 bcast_off_q,
    output logic [NUM_DEST-1:0]  vec_q
);
    import pdf_pkg::*;

    typedef struct packed {
        logic [WORD_W-1:0]   host;
        logic                bcast_off;
        logic [NUM_DEST-1:0] vec;
    } cfg_t;

    cfg_t cfg_d, cfg_q;
    logic [NUM_WORDS-1:0] word_we;

    // one write enable per bitmap word
    for (genvar k = 0; k < NUM_WORDS; k++) begin : g_word_we
        assign word_we[k] = wr_en && (wr_sel == SEL_VEC) &&
                            (wr_idx == WIDX_W'(k));
    end

    always_comb begin
        cfg_d = cfg_q;
        if (wr_en && wr_sel == SEL_HOST) begin
            cfg_d.host = wr_data;
        end
        if (wr_en && wr_sel == SEL_CTRL) begin
            cfg_d.bcast_off = wr_data[0];
        end
        for (int k = 0; k < NUM_WORDS; k++) begin
            if (word_we[k]) begin
                cfg_d.vec[k*WORD_W +: WORD_W] = wr_data;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q <= '0;
        end else begin
            cfg_q <= cfg_d;
        end
    end

    assign host_q      = cfg_q.host;
    assign bcast_off_q = cfg_q.bcast_off;
    assign vec_q       = cfg_q.vec;

endmodule

// File: rtl/pdf_match.sv
module pdf_match #(
    parameter int ADDR_W = 8,
    parameter int WORD_W = 16,
    localparam int NUM_DEST = 1 << ADDR_W
) (
    input  logic [WORD_W-1:0]   host,
    input  logic                bcast_off,
    input  logic [NUM_DEST-1:0] vec,
    input  logic [ADDR_W-1:0]   dest,
    output logic                mc_mode,
    output logic                hit
);
    logic is_bcast;
    logic single_hit;

    assign mc_mode    = &host;
    assign is_bcast   = (dest == '0);
    // broadcast never matches through the host compare
    assign single_hit = is_bcast ? !bcast_off : (host == WORD_W'(dest));
    assign hit        = mc_mode ? vec[dest] : single_hit;

endmodule

// File: rtl/pdf_miss_ctr.sv
module pdf_miss_ctr #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             inc,
    input  logic             clr,
    output logic [CNT_W-1:0] count
);
    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } ctr_t;

    ctr_t ctr_d, ctr_q;

    always_comb begin
        ctr_d = ctr_q;
        if (clr) begin
            ctr_d.cnt = '0;
        end else if (inc && !(&ctr_q.cnt)) begin
            ctr_d.cnt = ctr_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctr_q <= '0;
        end else begin
            ctr_q <= ctr_d;
        end
    end

    assign count = ctr_q.cnt;

endmodule

// File: rtl/pkt_dest_filter.sv
module pkt_dest_filter #(
    parameter int ADDR_W = 8,
    parameter int WORD_W = 16,
    parameter int CNT_W  = 8,
    localparam int NUM_DEST  = 1 << ADDR_W,
    localparam int NUM_WORDS = NUM_DEST / WORD_W,
    localparam int WIDX_W    = (NUM_WORDS > 1) ? $clog2(NUM_WORDS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [1:0]        wr_sel,
    input  logic [WIDX_W-1:0] wr_idx,
    input  logic [WORD_W-1:0] wr_data,
    input  logic              dst_valid,
    input  logic [ADDR_W-1:0] dst_addr,
    input  logic              buf_ready,
    output logic              acc_valid,
    output logic              acc_ok,
    output logic              multicast_mode,
    output logic [CNT_W-1:0]  missed_count
);
    import pdf_pkg::*;

    typedef struct packed {
        logic valid;
        logic ok;
    } dec_t;

    pdf_sel_e             sel;
    logic [WORD_W-1:0]    host_q;
    logic                 bcast_off_q;
    logic [NUM_DEST-1:0]  vec_q;
    logic                 hit;
    logic                 miss_inc;
    logic                 miss_clr;
    dec_t                 dec_d, dec_q;

    assign sel = pdf_sel_e'(wr_sel);

    pdf_cfg_regs #(.ADDR_W(ADDR_W), .WORD_W(WORD_W)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .wr_sel     (sel),
        .wr_idx     (wr_idx),
        .wr_data    (wr_data),
        .host_q     (host_q),
        .bcast_off_q(bcast_off_q),
        .vec_q      (vec_q)
    );

    pdf_match #(.ADDR_W(ADDR_W), .WORD_W(WORD_W)) u_match (
        .host     (host_q),
        .bcast_off(bcast_off_q),
        .vec      (vec_q),
        .dest     (dst_addr),
        .mc_mode  (multicast_mode),
        .hit      (hit)
    );

    assign miss_inc = dst_valid && hit && !buf_ready;
    assign miss_clr = wr_en && (sel == SEL_MISS);

    pdf_miss_ctr #(.CNT_W(CNT_W)) u_miss (
        .clk  (clk),
        .rst_n(rst_n),
        .inc  (miss_inc),
        .clr  (miss_clr),
        .count(missed_count)
    );

    always_comb begin
        dec_d       = '0;
        dec_d.valid = dst_valid;
        dec_d.ok    = dst_valid && hit && buf_ready;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dec_q <= '0;
        end else begin
            dec_q <= dec_d;
        end
    end

    assign acc_valid = dec_q.valid;
    assign acc_ok    = dec_q.ok;

endmodule

// File: rtl/pdf_checker.sv
module pdf_checker #(
    parameter int ADDR_W = 8,
    parameter int WORD_W = 16,
    parameter int CNT_W  = 8,
    localparam int NUM_DEST  = 1 << ADDR_W,
    localparam int NUM_WORDS = NUM_DEST / WORD_W,
    localparam int WIDX_W    = (NUM_WORDS > 1) ? $clog2(NUM_WORDS) : 1
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic [1:0]        wr_sel,
    input logic [WORD_W-1:0] wr_data,
    input logic              dst_valid,
    input logic              buf_ready,
    input logic              acc_valid,
    input logic              acc_ok,
    input logic              multicast_mode,
    input logic [CNT_W-1:0]  missed_count
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    assert_valid_follows_R7: assert property (@(posedge clk) disable iff (!rst_n)
        dst_valid |=> acc_valid);
    assert_valid_drops_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !dst_valid |=> !acc_valid);
    assert_ok_needs_valid_R7: assert property (@(posedge clk) disable iff (!rst_n)
        acc_ok |-> acc_valid);
    assert_nobuf_refused_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (dst_valid && !buf_ready) |=> !acc_ok);
    assert_miss_step_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && wr_sel == 2'd3) |=>
            (missed_count == $past(missed_count) ||
             missed_count == $past(missed_count) + CNT_W'(1)));
    assert_miss_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!dst_valid && !(wr_en && wr_sel == 2'd3)) |=> $stable(missed_count));
    assert_no_overflow_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (missed_count == CNT_MAX && !(wr_en && wr_sel == 2'd3))
            |=> missed_count == CNT_MAX);
    assert_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_sel == 2'd3) |=> missed_count == '0);
    assert_enter_mc_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_sel == 2'd0 && (&wr_data)) |=> multicast_mode);
    assert_leave_mc_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_sel == 2'd0 && !(&wr_data)) |=> !multicast_mode);

endmodule

bind pkt_dest_filter pdf_checker #(
    .ADDR_W(ADDR_W),
    .WORD_W(WORD_W),
    .CNT_W (CNT_W)
) u_pdf_checker (
    .clk           (clk),
    .rst_n         (rst_n),
    .wr_en         (wr_en),
    .wr_sel        (wr_sel),
    .wr_data       (wr_data),
    .dst_valid     (dst_valid),
    .buf_ready     (buf_ready),
    .acc_valid     (acc_valid),
    .acc_ok        (acc_ok),
    .multicast_mode(multicast_mode),
    .missed_count  (missed_count)
);

// File: tb/pkt_dest_filter_test.sv
`timescale 1ns/1ps
module pkt_dest_filter_test;
    localparam int AW = 6;
    localparam int WW = 8;
    localparam int CW = 4;
    localparam int ND = 1 << AW;
    localparam int NW = ND / WW;
    localparam int IW = 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_en = 1'b0;
    logic [1:0]    wr_sel = '0;
    logic [IW-1:0] wr_idx = '0;
    logic [WW-1:0] wr_data = '0;
    logic          dst_valid = 1'b0;
    logic [AW-1:0] dst_addr = '0;
    logic          buf_ready = 1'b1;
    logic          acc_valid;
    logic          acc_ok;
    logic          multicast_mode;
    logic [CW-1:0] missed_count;

    int n_checks = 0;
    int n_fail = 0;
    bit done = 1'b0;

    logic [WW-1:0] m_host = '0;
    bit            m_boff = 1'b0;
    bit            m_vec [ND];
    int            m_miss = 0;

    always #2 clk = ~clk;

    pkt_dest_filter #(.ADDR_W(AW), .WORD_W(WW), .CNT_W(CW)) uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
        .wr_idx(wr_idx), .wr_data(wr_data), .dst_valid(dst_valid),
        .dst_addr(dst_addr), .buf_ready(buf_ready), .acc_valid(acc_valid),
        .acc_ok(acc_ok), .multicast_mode(multicast_mode),
        .missed_count(missed_count)
    );

    task automatic chk(string req, int act, int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic bit exp_hit(int d);
        if (m_host == '1) return m_vec[d];
        if (d == 0) return !m_boff;
        return int'(m_host) == d;
    endfunction

    task automatic wr(int sel, int idx, int data);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = 2'(sel); wr_idx = IW'(idx); wr_data = WW'(data);
        @(negedge clk);
        wr_en = 1'b0;
        case (sel)
            0: m_host = WW'(data);
            1: for (int n = 0; n < WW; n++) m_vec[idx*WW + n] = data[n];
            2: m_boff = data[0];
            default: m_miss = 0;
        endcase
    endtask

    task automatic probe(string req, int d, bit rdy);
        bit h;
        h = exp_hit(d);
        @(negedge clk);
        dst_valid = 1'b1; dst_addr = AW'(d); buf_ready = rdy;
        @(negedge clk);
        dst_valid = 1'b0; buf_ready = 1'b1;
        if (h && !rdy && m_miss < (1 << CW) - 1) m_miss++;
        chk({req, " acc_valid R7"}, int'(acc_valid), 1);
        chk({req, " acc_ok"}, int'(acc_ok), int'(h && rdy));
        chk({req, " missed_count R8"}, int'(missed_count), m_miss);
    endtask

    task automatic sweep(string req);
        for (int d = 0; d < ND; d++) probe(req, d, 1'b1);
    endtask

    initial begin
        repeat (10) begin
            @(posedge clk);
            if (done) break;
        end
        for (int c = 0; c < 150000 && !done; c++) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures",
                     n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < ND; i++) m_vec[i] = 1'b0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 acc_valid", int'(acc_valid), 0);
        chk("R1 acc_ok", int'(acc_ok), 0);
        chk("R1 missed_count", int'(missed_count), 0);
        chk("R1 multicast_mode", int'(multicast_mode), 0);
        sweep("R1 reset config");

        // R7 no strobe, no verdict
        @(negedge clk);
        chk("R7 idle acc_valid", int'(acc_valid), 0);
        chk("R7 idle acc_ok", int'(acc_ok), 0);

        // R2 single host
        wr(0, 0, 5);
        sweep("R2 host 5");
        wr(0, 0, ND - 1);
        sweep("R2 host top");

        // R3 broadcast off / on
        wr(2, 0, 1);
        sweep("R3 bcast off");
        wr(0, 0, 0);
        sweep("R3 bcast off host 0");
        wr(2, 0, 'hFE);
        sweep("R3 bcast on");

        // R4 / R5 multicast with computed pattern
        for (int k = 0; k < NW; k++) wr(1, k, (k * 37 + 11) & 'hFF);
        wr(0, 0, 'hFF);
        chk("R4 multicast_mode", int'(multicast_mode), 1);
        sweep("R4 pattern");
        wr(1, 0, 'h01);
        wr(1, NW - 1, 'h80);
        sweep("R5 word rewrite");
        for (int k = 0; k < NW; k++) wr(1, k, 0);
        sweep("R5 none selected");
        for (int k = 0; k < NW; k++) wr(1, k, 'hFF);
        wr(2, 0, 1);
        sweep("R5 all selected");
        wr(2, 0, 0);

        // R6 back to single host
        wr(0, 0, 'h80);
        chk("R6 multicast_mode", int'(multicast_mode), 0);
        sweep("R6 negative host");
        wr(0, 0, 33);
        sweep("R6 host 33");

        // R8 / R9 missed counter
        probe("R8 nomatch nobuf", 7, 1'b0);
        for (int i = 0; i < 18; i++) probe("R9 saturate", 33, 1'b0);
        chk("R9 at max", int'(missed_count), (1 << CW) - 1);
        probe("R8 bcast nobuf", 0, 1'b0);

        // R10 clear
        wr(3, 0, 'h5A);
        chk("R10 cleared", int'(missed_count), 0);
        probe("R10 after clear", 33, 1'b1);
        probe("R10 count again", 33, 1'b0);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures",
                 n_checks, n_fail);
        $finish;
    end
endmodule